// File: doc/BRIEF.md
# MFM Write Encoder with Precompensation

This block sits in the write channel of a fixed-disk controller. It takes bytes over a ready/valid handshake and turns them into a serial stream of modified-frequency-modulation (MFM) flux-transition slots, one slot per clock cycle. Each data bit becomes one cell of two slots: a clock slot followed by a data slot. For every slot the block also gives a two-bit timing code. A downstream delay stage uses this code to move that transition early or late, which offsets peak shift on the inner cylinders.

A per-byte mark flag selects address-mark encoding. In that mode one clock transition of the byte is left out, so that 0xA1 gives a sync pattern that normal data cannot produce. The current cylinder number decides whether precompensation is active. It also drives the reduced-write-current flag for the head driver. Bits are encoded only while the write gate is high. A cell is emitted only once the data bit after it is known, because that bit is needed for the precompensation decision.

Top module: `mfm_write_encoder`

## Requirements
- R1: Bytes are sent MSB first. Each data bit gives a clock slot and then a data slot. The data slot equals the bit. The clock slot is 1 exactly when the previous data bit and the current data bit are both 0. Data bits before the first bit after write gate rises count as 0.
- R2: When a byte carries the mark flag, the clock slot in front of its sixth transmitted bit (bit index 2, LSB = 0) is forced to 0. A marked 0xA1 that follows a 0x00 byte produces the slot word 0x4489, first slot in the MSB; the same byte unmarked produces 0x44A9.
- R3: `wr_shift` codes are 2'b00 on time, 2'b01 early and 2'b10 late. A non-zero code appears only on a slot that carries a transition, and 2'b11 never appears.
- R4: A data transition whose previous data bit is 0 and whose next data bit is 1 is coded late. One whose previous bit is 1 and next bit is 0 is coded early. Every other data transition is on time.
- R5: A clock transition whose data bit two cells earlier is 1 and whose next data bit is 0 is coded late. One whose data bit two cells earlier is 0 and whose next bit is 1 is coded early. Every other clock transition is on time.
- R6: Precompensation codes are produced only when `cyl` is greater than 128. At 128 and below, every code is 2'b00.
- R7: `red_wcur` is 1 for `cyl` values of 128 and above and 0 below 128. It follows `cyl` one clock later.
- R8: When bytes are offered back to back, the first clock slot of a burst appears after the fourth rising edge following the edge that accepts the first byte. Slots then follow one per cycle with no gap. A burst of N bytes yields 16N-2 slots.
- R9: A cell is held until the next data bit is available, and the outputs are 0 while it waits. When a byte is accepted at edge a after such a stall, the held cell's clock slot appears after edge a+3.
- R10: While write gate is low, `in_ready` is 0. One edge after write gate is sampled low, `wr_slot` and `wr_shift` are 0. Bits that are still pending are discarded, and the bit history restarts at 0.
- R11: Exactly one byte can be buffered. `in_ready` is 1 while write gate is high and the buffer is empty, and it drops after a byte is accepted.
- R12: Two consecutive slots never both carry a transition.
- R13: After a synchronous reset, `wr_slot`, `wr_shift`, `red_wcur` and `in_ready` are 0 while write gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one half-cell per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_gate | input | 1 | Write enable; encoding runs only while high |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte buffer can take a byte |
| in_byte | input | 8 | Byte to encode |
| in_mark | input | 1 | Encode this byte as an address mark |
| cyl | input | 10 | Current cylinder number |
| wr_slot | output | 1 | Transition flag for the current half-cell slot |
| wr_shift | output | 2 | Precompensation code for the current slot |
| red_wcur | output | 1 | Reduced write current request |

## Verification
The embedded properties check, on every cycle, the rules that hold locally. No two adjacent slots carry transitions. A timing code never appears without a transition or on an outer cylinder. The write-current flag follows the cylinder. The outputs fall silent after write gate drops. The one-byte buffer holds its content until the shifter takes it. What only the bench scenarios can show is the content of the stream: the MSB-first cell order, the exact early/late choice from neighbouring bits, the single missing clock of a marked byte, the priming and stall latencies, and the history that restarts after write gate rises again. The bench compares every slot of each burst against a model built from the requirements.

// File: rtl/mfm_enc_pkg.sv
// Shared types and precompensation decision rules for the MFM write encoder.
// Assumes slot codes are consumed by an external delay stage.
package mfm_enc_pkg;

    typedef enum logic [1:0] {
        SHIFT_NONE  = 2'b00,
        SHIFT_EARLY = 2'b01,
        SHIFT_LATE  = 2'b10
    } shift_e;

    // Data transition: decided by the previous and next data bits.
    function automatic shift_e data_shift(input logic prv, input logic nxt);
        if (!prv && nxt)
            return SHIFT_LATE;
        else if (prv && !nxt)
            return SHIFT_EARLY;
        else
            return SHIFT_NONE;
    endfunction

    // Clock transition: decided by the data bit two cells back and the next one.
    function automatic shift_e clock_shift(input logic prv2, input logic nxt);
        if (prv2 && !nxt)
            return SHIFT_LATE;
        else if (!prv2 && nxt)
            return SHIFT_EARLY;
        else
            return SHIFT_NONE;
    endfunction

endpackage

// File: rtl/mfm_byte_feed.sv
// One-byte input buffer plus an MSB-first bit shifter.
// Presents one data bit at a time to the cell window and flags the bit whose
// leading clock must be dropped in address-mark bytes. Cleared while the
// write gate is low, so no stale bits survive a gate cycle.
module mfm_byte_feed #(
    parameter int BYTE_W       = 8,
    parameter int MARK_GAP_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_mark,
    input  logic              take,
    output logic              bit_avail,
    output logic              bit_out,
    output logic              bit_noclk
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] buf_q;
    logic              buf_mark;
    logic              buf_full;
    logic [BYTE_W-1:0] sh_q;
    logic              sh_mark;
    logic [CNT_W-1:0]  cnt;

    assign in_ready  = gate && !buf_full;
    assign bit_avail = (cnt != '0);
    assign bit_out   = sh_q[BYTE_W-1];
    assign bit_noclk = sh_mark && (cnt == CNT_W'(MARK_GAP_BIT + 1));

    // Buffer accept, shifter load from the buffer, and bit-by-bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) begin
            buf_q    <= '0;
            buf_mark <= 1'b0;
            buf_full <= 1'b0;
            sh_q     <= '0;
            sh_mark  <= 1'b0;
            cnt      <= '0;
        end else begin
            if (in_valid && in_ready) begin
                buf_q    <= in_byte;
                buf_mark <= in_mark;
                buf_full <= 1'b1;
            end
            if (cnt == '0 && buf_full) begin
                sh_q     <= buf_q;
                sh_mark  <= buf_mark;
                cnt      <= CNT_W'(BYTE_W);
                buf_full <= 1'b0;
            end else if (take && cnt != '0) begin
                sh_q <= sh_q << 1;
                cnt  <= cnt - 1'b1;
            end
        end
    end

    // R11
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && buf_full && cnt != '0) |=> buf_full);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/mfm_cell_window.sv
// Four-bit sliding window of data bits (two back, one back, current, next).
// Judges the current bit: emits its clock slot, then its data slot, each with
// a precompensation code. A cell waits until its next bit has arrived.
// Assumes the feed presents a bit whenever bit_avail is high.
module mfm_cell_window
    import mfm_enc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   gate,
    input  logic   precomp_en,
    input  logic   bit_avail,
    input  logic   bit_in,
    input  logic   noclk_in,
    output logic   take,
    output logic   slot_bit,
    output shift_e slot_shift
);
    logic hist2, hist1, cur, nxt;
    logic noclk_cur, noclk_nxt;
    logic v_cur, v_nxt;
    logic ph;
    logic clk_t;

    // Slot value, precompensation code and bit request for this cycle.
    always_comb begin
        take       = 1'b0;
        slot_bit   = 1'b0;
        slot_shift = SHIFT_NONE;
        clk_t      = !hist1 && !cur && !noclk_cur;
        if (ph) begin
            take       = bit_avail;
            slot_bit   = cur;
            slot_shift = (precomp_en && cur) ? data_shift(hist1, nxt) : SHIFT_NONE;
        end else if (v_cur && v_nxt) begin
            slot_bit   = clk_t;
            slot_shift = (precomp_en && clk_t) ? clock_shift(hist2, nxt) : SHIFT_NONE;
        end else begin
            take = bit_avail;
        end
    end

    // Window advance after a data slot, and priming/refill while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) begin
            hist2     <= 1'b0;
            hist1     <= 1'b0;
            cur       <= 1'b0;
            nxt       <= 1'b0;
            noclk_cur <= 1'b0;
            noclk_nxt <= 1'b0;
            v_cur     <= 1'b0;
            v_nxt     <= 1'b0;
            ph        <= 1'b0;
        end else if (ph) begin
            hist2     <= hist1;
            hist1     <= cur;
            cur       <= nxt;
            noclk_cur <= noclk_nxt;
            v_cur     <= v_nxt;
            nxt       <= bit_in;
            noclk_nxt <= noclk_in;
            v_nxt     <= bit_avail;
            ph        <= 1'b0;
        end else if (v_cur && v_nxt) begin
            ph <= 1'b1;
        end else if (bit_avail) begin
            if (!v_cur) begin
                hist2     <= hist1;
                hist1     <= cur;
                cur       <= nxt;
                noclk_cur <= noclk_nxt;
                v_cur     <= v_nxt;
            end
            nxt       <= bit_in;
            noclk_nxt <= noclk_in;
            v_nxt     <= 1'b1;
        end
    end

    // R9
    hold_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph |-> (v_cur && v_nxt));

endmodule

// File: rtl/mfm_write_encoder.sv
// MFM write encoder top: byte feed, cell window, registered slot outputs and
// cylinder-based precompensation and write-current decisions.
// Assumes one clock cycle per half-cell slot.
module mfm_write_encoder
    import mfm_enc_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int CYL_W         = 10,
    parameter int PRECOMP_ABOVE = 128,
    parameter int RWC_FROM      = 128,
    parameter int MARK_GAP_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_gate,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_mark,
    input  logic [CYL_W-1:0]  cyl,
    output logic              wr_slot,
    output logic [1:0]        wr_shift,
    output logic              red_wcur
);
    logic   take, bit_avail, bit_val, bit_noclk;
    logic   slot_bit;
    shift_e slot_shift;
    logic   precomp_en;

    assign precomp_en = (cyl > CYL_W'(PRECOMP_ABOVE));

    mfm_byte_feed #(
        .BYTE_W       (BYTE_W),
        .MARK_GAP_BIT (MARK_GAP_BIT)
    ) feed_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (wr_gate),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_byte   (in_byte),
        .in_mark   (in_mark),
        .take      (take),
        .bit_avail (bit_avail),
        .bit_out   (bit_val),
        .bit_noclk (bit_noclk)
    );

    mfm_cell_window win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate       (wr_gate),
        .precomp_en (precomp_en),
        .bit_avail  (bit_avail),
        .bit_in     (bit_val),
        .noclk_in   (bit_noclk),
        .take       (take),
        .slot_bit   (slot_bit),
        .slot_shift (slot_shift)
    );

    // Output register: slot and code, muted while the gate is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot  <= 1'b0;
            wr_shift <= SHIFT_NONE;
            red_wcur <= 1'b0;
        end else begin
            wr_slot  <= wr_gate && slot_bit;
            wr_shift <= wr_gate ? slot_shift : SHIFT_NONE;
            red_wcur <= (cyl >= CYL_W'(RWC_FROM));
        end
    end

    // R12
    no_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_slot |=> !wr_slot);

    // R3
    code_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_shift != SHIFT_NONE) |-> (wr_slot && wr_shift != 2'b11));

    // R6
    outer_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyl > CYL_W'(PRECOMP_ABOVE)) |=> (wr_shift == SHIFT_NONE));

    // R7
    rwc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (red_wcur == $past(cyl >= CYL_W'(RWC_FROM))));

    // R10
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gate |=> (!wr_slot && wr_shift == SHIFT_NONE));

endmodule

// File: tb/mfm_write_encoder_tb.sv
// Self-checking bench: per-slot comparison of encoded bursts against a
// requirement-derived model, plus directed corner cases.
module mfm_write_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_gate;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_byte;
    logic       in_mark;
    logic [9:0] cyl;
    logic       wr_slot;
    logic [1:0] wr_shift;
    logic       red_wcur;

    always #10 clk = ~clk;

    mfm_write_encoder dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_gate  (wr_gate),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_byte  (in_byte),
        .in_mark  (in_mark),
        .cyl      (cyl),
        .wr_slot  (wr_slot),
        .wr_shift (wr_shift),
        .red_wcur (red_wcur)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;
    logic [7:0] sb [64];
    logic       sm [64];
    int         nb;
    logic       exp_bit [1024];
    logic [1:0] exp_sh  [1024];
    logic       act_bit [1024];

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic get_bit(input int i);
        if (i < 0) return 1'b0;
        return sb[i / 8][7 - (i % 8)];
    endfunction

    // Model of the slot stream from R1, R2, R4, R5, R6.
    function automatic void build_expect(input logic pc_on);
        for (int i = 0; i < 8 * nb - 1; i++) begin
            logic h2, h1, c, nx, drop, ck;
            h2   = get_bit(i - 2);
            h1   = get_bit(i - 1);
            c    = get_bit(i);
            nx   = get_bit(i + 1);
            drop = sm[i / 8] && ((i % 8) == 5);
            ck   = !h1 && !c && !drop;
            exp_bit[2*i]   = ck;
            exp_sh[2*i]    = (pc_on && ck) ? ((h2 && !nx) ? 2'b10 : ((!h2 && nx) ? 2'b01 : 2'b00)) : 2'b00;
            exp_bit[2*i+1] = c;
            exp_sh[2*i+1]  = (pc_on && c) ? ((!h1 && nx) ? 2'b10 : ((h1 && !nx) ? 2'b01 : 2'b00)) : 2'b00;
        end
    endfunction

    // Feed nb bytes (optionally withholding from byte gap_after) and compare every cycle.
    task automatic run_stream(input int gap_after, input int gap_len, input logic pc_on);
        int   idx = 0, m = -1, seg_start = -1, seg_lim = 0, slot = 0, hold = 0, tail = 0;
        int   total = 16 * nb - 2;
        int   lim0  = (gap_after > 0) ? 16 * gap_after - 2 : total;
        logic acc;
        build_expect(pc_on);
        wr_gate = 1'b1;
        for (int it = 0; it < 16 * nb + gap_len + 64; it++) begin
            if (idx < nb && !(idx == gap_after && hold < gap_len)) begin
                in_valid = 1'b1;
                in_byte  = sb[idx];
                in_mark  = sm[idx];
            end else begin
                in_valid = 1'b0;
                if (idx == gap_after) hold++;
            end
            #1;
            acc = in_valid && in_ready;
            @(posedge clk);
            m++;
            if (acc) begin
                if (idx == 0) begin
                    seg_start = m + 4;       // R8 priming latency
                    seg_lim   = lim0;
                end else if (idx == gap_after) begin
                    seg_start = m + 3;       // R9 resume latency
                    seg_lim   = total;
                end
                idx++;
            end
            @(negedge clk);
            if (seg_start >= 0 && m >= seg_start && slot < seg_lim) begin
                act_bit[slot] = wr_slot;
                chk(sm[slot / 16] ? "R2" : "R1", 32'(wr_slot), 32'(exp_bit[slot]), "slot bit");
                chk(!pc_on ? "R6 R3" : ((slot % 2 == 0) ? "R5 R3" : "R4 R3"),
                    32'(wr_shift), 32'(exp_sh[slot]), "slot code");
                slot++;
            end else begin
                chk("R9", {29'd0, wr_slot, wr_shift}, 32'd0, "idle slot");
                if (slot == total) tail++;
            end
            if (tail == 4) break;
        end
        chk("R8", 32'(slot), 32'(total), "slot count");
        in_valid = 1'b0;
        wr_gate  = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] word_at(input int base);
        logic [15:0] w;
        for (int k = 0; k < 16; k++) w[15 - k] = act_bit[base + k];
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_gate = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_mark = 1'b0; cyl = 10'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13 reset state
        chk("R13", {29'd0, wr_slot, wr_shift}, 32'd0, "reset slot");
        chk("R13", 32'(red_wcur), 32'd0, "reset rwc");
        chk("R13", 32'(in_ready), 32'd0, "reset ready");
        rst_n = 1'b1;

        // R7 write-current boundary
        foreach (sb[i]) begin sb[i] = 8'h00; sm[i] = 1'b0; end
        cyl = 10'd127; @(posedge clk); @(negedge clk);
        chk("R7", 32'(red_wcur), 32'd0, "cyl 127");
        cyl = 10'd128; @(posedge clk); @(negedge clk);
        chk("R7", 32'(red_wcur), 32'd1, "cyl 128");
        cyl = 10'd255; @(posedge clk); @(negedge clk);
        chk("R7", 32'(red_wcur), 32'd1, "cyl 255");
        cyl = 10'd0; @(posedge clk); @(negedge clk);
        chk("R7", 32'(red_wcur), 32'd0, "cyl 0");

        // R11 handshake and R10 ready while gate low
        in_valid = 1'b1; in_byte = 8'h5A; #1;
        chk("R10", 32'(in_ready), 32'd0, "ready with gate low");
        wr_gate = 1'b1; #1;
        chk("R11", 32'(in_ready), 32'd1, "ready with empty buffer");
        @(posedge clk); @(negedge clk);
        chk("R11", 32'(in_ready), 32'd0, "ready after accept");
        in_valid = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        // R10 gate drop mid-byte
        wr_gate = 1'b0; #1;
        chk("R10", 32'(in_ready), 32'd0, "ready after gate drop");
        @(posedge clk); @(negedge clk);
        chk("R10", {29'd0, wr_slot, wr_shift}, 32'd0, "slot after gate drop");

        // R10 history restart plus R2 address mark, cylinder 0
        nb = 3; sb[0] = 8'h00; sb[1] = 8'hA1; sb[2] = 8'h00; sm[1] = 1'b1;
        run_stream(-1, 0, 1'b0);
        chk("R2", 32'(word_at(16)), 32'h4489, "marked A1 word");
        sm[1] = 1'b0;
        run_stream(-1, 0, 1'b0);
        chk("R2", 32'(word_at(16)), 32'h44A9, "unmarked A1 word");

        // R6 precompensation boundary with the same pattern
        nb = 4; sb[0] = 8'h36; sb[1] = 8'h4C; sb[2] = 8'hB5; sb[3] = 8'h01;
        cyl = 10'd128; run_stream(-1, 0, 1'b0);
        cyl = 10'd129; run_stream(-1, 0, 1'b1);
        // R9 stall in the middle
        run_stream(2, 50, 1'b1);

        // Random bursts
        for (int s = 0; s < 10; s++) begin
            nb = 3 + $urandom_range(0, 7);
            for (int i = 0; i < nb; i++) begin
                sb[i] = 8'($urandom);
                sm[i] = ($urandom_range(0, 4) == 0);
                if (sm[i] && $urandom_range(0, 1) == 1) sb[i] = 8'hA1;
            end
            cyl = 10'($urandom_range(0, 300));
            run_stream((s % 2 == 1) ? $urandom_range(1, nb - 1) : -1, 50, cyl > 10'd128);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule